// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple register bus. A down-counter is clocked by a tick enable that comes from a programmable prescaler. The first time the counter expires, the block raises a level interrupt and starts counting again from the reload value. If software has not serviced that interrupt by the next expiry, and reset generation is enabled, the block emits a one-cycle system reset request. The effective time before a reset is therefore two reload periods.

Software feeds the watchdog by acknowledging the interrupt. This clears the pending flag and restarts the count. The configuration registers are protected by a key. Writing the key value opens them. Writing anything else closes them again. While the registers are closed, writes to them are dropped, but every register can still be read.

Word addresses are as follows:
- 0: key. Reads 1 while locked.
- 1: control. Bit 0 is the interrupt/run enable and bit 1 is the reset enable.
- 2: reload value.
- 3: feed. Write-only; reads 0.
- 4: status. Bit 0 is the pending interrupt.
- 5: divider. A 4-bit field at bits 7:4.

Top module: `wdtTimer`

## Requirements
- R1: After reset the block is locked, so address 0 reads 1. Control reads 0, reload reads all ones, status reads 0, and both irqOut and rstReq are low.
- R2: Writing the key value (default 32'h5A5AC3C3) to address 0 unlocks the block, after which address 0 reads 0. Writing any other value to address 0, including the bitwise inverse of the key, locks it again.
- R3: While the block is locked, writes to addresses 1, 2, 3 and 5 leave every register, irqOut and the count unchanged. Reads still return the current values.
- R4: While control bit 0 is 0, the counter and prescaler hold, and no interrupt is raised.
- R5: With the divider field at 0, a write of L to address 2 stores L and restarts the count. irqOut then rises L+1 clock cycles after the write edge.
- R6: irqOut is a level. It stays high from an expiry until it is cleared through address 3, even across further expiries.
- R7: Writing address 3 with bit 0 set clears irqOut and reloads the count from the reload value. A write with bit 0 clear has no effect.
- R8: rstReq pulses high for exactly one cycle when the count expires while irqOut is already high and control bit 1 is 1. With L loaded and the divider at 0, this happens 2(L+1) cycles after the load. When control bit 1 is 0, rstReq stays low.
- R9: A divider field value N in bits 7:4 of address 5 makes the counter step once every N+1 cycles, so the first expiry comes (L+1)(N+1) cycles after the load. The other bits of address 5 read 0.
- R10: Address 4 bit 0 reads the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 3 | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr (combinational) |
| irqOut | output | 1 | Level interrupt, high while an expiry is unserviced |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The reset request is the hardest state to reach from the ports. Two full expiries must pass with nothing writing the feed address in between, and the interrupt from the first expiry must still be pending when the second one arrives. The stimulus first clears any old interrupt and then loads a short reload value, so that both expiries fall on predictable cycles. It then watches the cycles on either side of the predicted pulse. A second hard case is a feed that arrives while the block is locked and the interrupt is pending. The bench lets the interrupt rise with the key closed, then checks that the feed write leaves it high.

// File: rtl/wdtPkg.sv
package wdtPkg;
  localparam int ADDR_W  = 3;
  localparam int DIV_W   = 4;
  localparam int DIV_LSB = 4;

  localparam logic [ADDR_W-1:0] A_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_FEED   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrReload;
    logic             feed;
    logic             run;
    logic [DIV_W-1:0] divN;
  } wdtStrobe_t;
endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              expire,
  output logic [DATA_W-1:0] reloadVal
);
  logic [DIV_W-1:0]  preCnt;
  logic [DATA_W-1:0] count;
  logic              tick;
  logic              restart;

  assign restart = stb.wrReload || stb.feed;
  assign tick    = stb.run && (preCnt == stb.divN);
  assign expire  = tick && (count == '0) && !restart;

  // prescaler: one tick every divN+1 cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!stb.run || restart || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '1;
    end else if (stb.wrReload) begin
      reloadVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '1;
    end else if (stb.wrReload) begin
      count <= wrData;
    end else if (stb.feed) begin
      count <= reloadVal;
    end else if (tick) begin
      count <= (count == '0) ? reloadVal : count - 1'b1;
    end
  end
endmodule

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import wdtPkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY_TOKEN = 32'h5A5AC3C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] reloadVal,
  output wdtStrobe_t        stb,
  output logic              irqOut,
  output logic              rstReq
);
  logic             locked;
  logic             intEn;
  logic             resEn;
  logic             irqPend;
  logic             rstPulse;
  logic [DIV_W-1:0] divN;
  logic             wrOk;
  logic             feedStb;

  assign wrOk    = busWe && !locked;
  assign feedStb = wrOk && (busAddr == A_FEED) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b1;
      intEn    <= 1'b0;
      resEn    <= 1'b0;
      divN     <= '0;
      irqPend  <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      if (busWe && busAddr == A_KEY) locked <= (busWdata != KEY_TOKEN);
      if (wrOk && busAddr == A_CTRL) begin
        intEn <= busWdata[0];
        resEn <= busWdata[1];
      end
      if (wrOk && busAddr == A_DIV) divN <= busWdata[DIV_LSB +: DIV_W];
      if (feedStb) irqPend <= 1'b0;
      else if (expire) irqPend <= 1'b1;
      rstPulse <= expire && irqPend && resEn && !feedStb && !rstPulse;
    end
  end

  assign stb.wrReload = wrOk && (busAddr == A_RELOAD);
  assign stb.feed     = feedStb;
  assign stb.run      = intEn;
  assign stb.divN     = divN;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_KEY:    busRdata[0] = locked;
      A_CTRL:   busRdata[1:0] = {resEn, intEn};
      A_RELOAD: busRdata = reloadVal;
      A_STATUS: busRdata[0] = irqPend;
      A_DIV:    busRdata[DIV_LSB +: DIV_W] = divN;
      default:  busRdata = '0;
    endcase
  end

  assign irqOut = irqPend;
  assign rstReq = rstPulse;
endmodule

// File: rtl/wdtTimer.sv
module wdtTimer
  import wdtPkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY_TOKEN = 32'h5A5AC3C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rstReq
);
  wdtStrobe_t        stb;
  logic              expire;
  logic [DATA_W-1:0] reloadVal;

  wdtCtrl #(.DATA_W(DATA_W), .KEY_TOKEN(KEY_TOKEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .expire(expire),
    .reloadVal(reloadVal), .stb(stb), .irqOut(irqOut), .rstReq(rstReq)
  );

  wdtDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .expire(expire), .reloadVal(reloadVal)
  );
endmodule

// File: rtl/wdtTimerChecker.sv
module wdtTimerChecker
  import wdtPkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY_TOKEN = 32'h5A5AC3C3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input logic              rstReq
);
  logic lockM;
  logic feedWr;

  assign feedWr = busWe && (busAddr == A_FEED) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockM <= 1'b1;
    else if (busWe && busAddr == A_KEY) lockM <= (busWdata != KEY_TOKEN);
  end

  assert_reset_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  assert_reset_needs_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (irqOut && $past(irqOut)));

  assert_irq_cleared_by_feed_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(feedWr && !lockM));

  assert_locked_feed_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && feedWr && lockM) |=> irqOut);
endmodule

bind wdtTimer wdtTimerChecker #(.DATA_W(DATA_W), .KEY_TOKEN(KEY_TOKEN)) chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .irqOut(irqOut), .rstReq(rstReq)
);

// File: tb/wdtTimer_tb_top.sv
module wdtTimer_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TOKEN      = 32'h5A5AC3C3;

  typedef struct packed {
    logic        rd;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h1,        4'd1},  // R1 locked
    '{1'b1, 3'd1, 32'h0,        4'd1},  // R1 control 0
    '{1'b1, 3'd2, 32'hFFFFFFFF, 4'd1},  // R1 reload ones
    '{1'b1, 3'd4, 32'h0,        4'd10}, // R10 no pending
    '{1'b0, 3'd2, 32'h10,       4'd3},  // R3 locked reload write
    '{1'b1, 3'd2, 32'hFFFFFFFF, 4'd3},
    '{1'b0, 3'd1, 32'h3,        4'd3},  // R3 locked control write
    '{1'b1, 3'd1, 32'h0,        4'd3},
    '{1'b0, 3'd0, TOKEN,        4'd2},  // R2 unlock
    '{1'b1, 3'd0, 32'h0,        4'd2},
    '{1'b0, 3'd2, 32'h1234,     4'd5},  // R5 reload store
    '{1'b1, 3'd2, 32'h1234,     4'd5},
    '{1'b0, 3'd5, 32'hFF,       4'd9},  // R9 only bits 7:4 kept
    '{1'b1, 3'd5, 32'hF0,       4'd9},
    '{1'b0, 3'd0, ~TOKEN,       4'd2},  // R2 inverse locks
    '{1'b1, 3'd0, 32'h1,        4'd2},
    '{1'b0, 3'd5, 32'h0,        4'd3},  // R3 locked divider write
    '{1'b1, 3'd5, 32'hF0,       4'd3},
    '{1'b0, 3'd0, TOKEN,        4'd2},
    '{1'b0, 3'd5, 32'h0,        4'd9},
    '{1'b1, 3'd5, 32'h0,        4'd9},
    '{1'b1, 3'd1, 32'h0,        4'd4}   // R4 still idle
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        rstReq;
  int          checks = 0;
  int          fails = 0;
  bit          doneFlag = 1'b0;

  wdtTimer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .rstReq(rstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [31:0] exp, input string req);
    busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1", {30'b0, irqOut, rstReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) busRead(VECS[i].addr, VECS[i].data, $sformatf("R%0d", VECS[i].req));
      else busWrite(VECS[i].addr, VECS[i].data);
    end

    // R4: counter idle with enable off
    busWrite(3'd2, 32'd2);
    waitCyc(10);
    chk("R4", {31'b0, irqOut}, 32'h0);

    // R5: first expiry at L+1 cycles
    busWrite(3'd1, 32'h1);
    busWrite(3'd2, 32'd4);
    waitCyc(4);
    chk("R5", {31'b0, irqOut}, 32'h0);
    waitCyc(1);
    chk("R5", {31'b0, irqOut}, 32'h1);
    busRead(3'd4, 32'h1, "R10");

    // R6 and R8: stays pending through second expiry, no reset without enable
    for (int c = 0; c < 8; c++) begin
      waitCyc(1);
      chk("R8", {31'b0, rstReq}, 32'h0);
      chk("R6", {31'b0, irqOut}, 32'h1);
    end

    // R7: feed with bit0 clear ignored, bit0 set clears
    busWrite(3'd3, 32'h2);
    chk("R7", {31'b0, irqOut}, 32'h1);
    busWrite(3'd3, 32'h1);
    chk("R7", {31'b0, irqOut}, 32'h0);

    // R3: feed while locked is ignored
    busWrite(3'd0, 32'h0);
    waitCyc(6);
    chk("R5", {31'b0, irqOut}, 32'h1);
    busWrite(3'd3, 32'h1);
    chk("R3", {31'b0, irqOut}, 32'h1);
    busRead(3'd1, 32'h1, "R3");
    busWrite(3'd0, TOKEN);

    // R8: reset pulse on second unserviced expiry
    busWrite(3'd1, 32'h3);
    busWrite(3'd3, 32'h1);
    busWrite(3'd2, 32'd4);
    waitCyc(5);
    chk("R8", {30'b0, irqOut, rstReq}, 32'h2);
    waitCyc(4);
    chk("R8", {31'b0, rstReq}, 32'h0);
    waitCyc(1);
    chk("R8", {31'b0, rstReq}, 32'h1);
    waitCyc(1);
    chk("R8", {30'b0, irqOut, rstReq}, 32'h2);

    // R7: regular feeding keeps both outputs low
    busWrite(3'd3, 32'h1);
    for (int f = 0; f < 10; f++) begin
      waitCyc(2);
      chk("R7", {30'b0, irqOut, rstReq}, 32'h0);
      busWrite(3'd3, 32'h1);
    end

    // R9: divide by 3, L=2 -> expiry 9 cycles after load
    busWrite(3'd1, 32'h1);
    busWrite(3'd5, 32'h20);
    busWrite(3'd3, 32'h1);
    busWrite(3'd2, 32'd2);
    waitCyc(8);
    chk("R9", {31'b0, irqOut}, 32'h0);
    waitCyc(1);
    chk("R9", {31'b0, irqOut}, 32'h1);
    busRead(3'd5, 32'h20, "R9");

    // R4: disabled counter never expires
    busWrite(3'd3, 32'h1);
    busWrite(3'd1, 32'h0);
    waitCyc(50);
    chk("R4", {30'b0, irqOut, rstReq}, 32'h0);

    // R1: reset mid-run
    busWrite(3'd1, 32'h1);
    waitCyc(12);
    rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
    busRead(3'd0, 32'h1, "R1");
    busRead(3'd1, 32'h0, "R1");
    busRead(3'd2, 32'hFFFFFFFF, "R1");
    busRead(3'd5, 32'h0, "R1");
    chk("R1", {30'b0, irqOut, rstReq}, 32'h0);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule